// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges the level-sensitive interrupt pins of a row of device slots onto a few shared interrupt lines. Each slot has four pins. A fixed rotating swizzle picks the line for each pin: the slot number plus the pin index, taken modulo the number of lines. Each line keeps a count of how many of the pins routed to it are asserted. The line is driven high while that count is nonzero, which gives the same result as a wired-OR while holding real state for every line.

The block keeps the last level it has seen for every pin. Each cycle it samples the pin inputs into a register and compares them with the stored levels. It then takes one real change per cycle, always the lowest flat index, and applies it to the counter of the line that pin routes to. Under a burst of changes the stored levels converge one pin at a time, and no counter update is ever lost or doubled. The line outputs are registered from the counters.

Top module: `irq_line_aggregator`

## Requirements
- R1: Synchronous reset clears every line counter, every stored pin level and every line output to 0. A pin that is still high when reset is released counts as a new rise.
- R2: The pin at flat index i = s*PINS + p (slot s, pin p) is routed to line (s + p) mod LINES.
- R3: A real rising change adds 1 to the routed line's count and a real falling change subtracts 1. A line is high exactly when its count is nonzero, so a shared line stays high until the last pin routed to it drops.
- R4: A pin level equal to the stored level is ignored. A pin held high for many cycles is counted once, and a single fall then clears its line.
- R5: When several pins differ from their stored levels, one change is applied per cycle in ascending flat index order. With all 32 pins of an 8-slot, 4-line build rising together, line k goes high exactly one cycle after line k-1.
- R6: A single pin change shows on its line at the third rising clock edge, counting the edge that first samples the new level. The line still shows the old value after the second edge.
- R7: Counters are wide enough for every pin to be asserted at once. Raising all pins and then dropping all of them returns every line to 0, with no overflow and no decrement below zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_lvl | input | SLOTS*PINS | Pin levels; bit s*PINS+p is pin p of slot s |
| line_out | output | LINES | Shared interrupt line levels, registered |

## Verification
A counter that is off by one shows up at the ports in one of two ways: a line that stays high after every routed pin has dropped, or a line that falls while a routed pin is still high. Either appears once the pending changes have drained, which takes at most one cycle per changed pin plus the fixed three-edge latency. A wrong routing or a wrong processing order shows up sooner, as a line rising in the wrong place or at the wrong cycle after a burst. A stored level that reset fails to clear shows up as a line that stays low after reset is released with the pin still high.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  // Rotating swizzle: line = (slot + pin) mod lines
  function automatic int unsigned route_line(int unsigned flat_idx,
                                             int unsigned pins,
                                             int unsigned lines);
    int unsigned slot;
    int unsigned pin;
    slot = flat_idx / pins;
    pin  = flat_idx % pins;
    return (slot + pin) % lines;
  endfunction

  // Index width with a floor of one bit
  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Counter width that can hold the value n
  function automatic int unsigned count_width(int unsigned n);
    return (n > 0) ? $clog2(n + 1) : 1;
  endfunction

endpackage

// File: rtl/irqagg_pick.sv
module irqagg_pick #(
  parameter int unsigned N  = 128,
  parameter int unsigned IW = 7
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Lowest set index wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/irqagg_level_store.sv
module irqagg_level_store #(
  parameter int unsigned N  = 128,
  parameter int unsigned IW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pin_lvl,
  output logic [N-1:0]  lvl_seen,
  output logic          ev_valid,
  output logic [IW-1:0] ev_idx,
  output logic          ev_rise
);

  logic [N-1:0] samp_q;
  logic [N-1:0] pend;

  // Pins whose sampled level differs from the stored one
  assign pend = samp_q ^ lvl_seen;

  irqagg_pick #(.N(N), .IW(IW)) u_pick (
    .req   (pend),
    .found (ev_valid),
    .idx   (ev_idx)
  );

  assign ev_rise = samp_q[ev_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q   <= '0;
      lvl_seen <= '0;
    end else begin
      samp_q <= pin_lvl;
      if (ev_valid) begin
        lvl_seen[ev_idx] <= samp_q[ev_idx];
      end
    end
  end

endmodule

// File: rtl/irqagg_line_ctr.sv
module irqagg_line_ctr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          busy
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else begin
      if (inc) begin
        cnt <= cnt + CW'(1);
      end else if (dec) begin
        cnt <= cnt - CW'(1);
      end
      busy <= (cnt != '0);
    end
  end

endmodule

// File: rtl/irq_line_aggregator.sv
module irq_line_aggregator #(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned PINS  = 4,
  parameter int unsigned LINES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SLOTS*PINS-1:0]  pin_lvl,
  output logic [LINES-1:0]       line_out
);

  import irqagg_pkg::*;

  localparam int unsigned NPIN = SLOTS * PINS;
  localparam int unsigned IW   = idx_width(NPIN);
  localparam int unsigned LW   = idx_width(LINES);
  localparam int unsigned CW   = count_width(NPIN);

  logic [NPIN-1:0]     lvl_seen;
  logic                ev_valid;
  logic [IW-1:0]       ev_idx;
  logic                ev_rise;
  logic [LW-1:0]       ev_line;
  logic [LINES*CW-1:0] cnt_flat;

  irqagg_level_store #(.N(NPIN), .IW(IW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .pin_lvl  (pin_lvl),
    .lvl_seen (lvl_seen),
    .ev_valid (ev_valid),
    .ev_idx   (ev_idx),
    .ev_rise  (ev_rise)
  );

  assign ev_line = LW'(route_line(32'(ev_idx), PINS, LINES));

  for (genvar k = 0; k < LINES; k++) begin : g_line
    logic hit;
    assign hit = ev_valid && (ev_line == LW'(k));
    irqagg_line_ctr #(.CW(CW)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .inc  (hit && ev_rise),
      .dec  (hit && !ev_rise),
      .cnt  (cnt_flat[k*CW +: CW]),
      .busy (line_out[k])
    );
  end

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
  parameter int unsigned NPIN  = 128,
  parameter int unsigned LINES = 4,
  parameter int unsigned LW    = 2,
  parameter int unsigned CW    = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [NPIN-1:0]     lvl_seen,
  input logic                ev_valid,
  input logic                ev_rise,
  input logic [LW-1:0]       ev_line,
  input logic [LINES*CW-1:0] cnt_flat,
  input logic [LINES-1:0]    line_out
);

  logic [CW-1:0] sel_cnt;
  int            cnt_sum;

  always_comb begin
    sel_cnt = '0;
    cnt_sum = 0;
    for (int k = 0; k < LINES; k++) begin
      if (ev_line == LW'(k)) sel_cnt = cnt_flat[k*CW +: CW];
      cnt_sum = cnt_sum + int'(cnt_flat[k*CW +: CW]);
    end
  end

  // R7: a fall never hits an empty counter
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_rise) |-> (sel_cnt != '0));

  // R3: total of the counts equals the number of pins stored high
  a_r3_sum_matches: assert property (@(posedge clk) disable iff (rst)
    cnt_sum == $countones(lvl_seen));

  // R4: with no change pending the counters hold
  a_r4_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !ev_valid |=> $stable(cnt_flat));

  // R5: at most one stored level changes per cycle
  a_r5_one_per_cycle: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(lvl_seen ^ $past(lvl_seen)) <= 1));

  for (genvar k = 0; k < LINES; k++) begin : g_follow
    // R3: a line follows its count one clock later
    a_r3_line_high: assert property (@(posedge clk) disable iff (rst)
      (cnt_flat[k*CW +: CW] != '0) |=> line_out[k]);
    a_r3_line_low: assert property (@(posedge clk) disable iff (rst)
      (cnt_flat[k*CW +: CW] == '0) |=> !line_out[k]);
  end

endmodule

bind irq_line_aggregator irqagg_checker #(
  .NPIN  (NPIN),
  .LINES (LINES),
  .LW    (LW),
  .CW    (CW)
) u_irqagg_chk (
  .clk      (clk),
  .rst      (rst),
  .lvl_seen (lvl_seen),
  .ev_valid (ev_valid),
  .ev_rise  (ev_rise),
  .ev_line  (ev_line),
  .cnt_flat (cnt_flat),
  .line_out (line_out)
);

// File: tb/test_irq_line_aggregator.sv
`timescale 1ns/100ps
module test_irq_line_aggregator;

  localparam int SL = 8;
  localparam int PN = 4;
  localparam int LN = 4;
  localparam int NP = SL * PN;
  localparam int SETTLE = NP + 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin_lvl = '0;
  logic [LN-1:0] line_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_line_aggregator #(.SLOTS(SL), .PINS(PN), .LINES(LN)) i_irq_line_aggregator (
    .clk      (clk),
    .rst      (rst),
    .pin_lvl  (pin_lvl),
    .line_out (line_out)
  );

  // Reference: OR of the pins routed to each line
  function automatic logic [LN-1:0] model(logic [NP-1:0] p);
    logic [LN-1:0] e;
    e = '0;
    for (int s = 0; s < SL; s++)
      for (int q = 0; q < PN; q++)
        if (p[s*PN + q]) e[(s + q) % LN] = 1'b1;
    return e;
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [LN-1:0] exp);
    checks++;
    if (line_out !== exp) begin
      errors++;
      $display("FAIL %s line_out=%b expected=%b", tag, line_out, exp);
    end
  endtask

  task automatic settle_check(string tag);
    step(SETTLE);
    check(tag, model(pin_lvl));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    // R1: reset state
    step(3);
    check("R1 during reset", '0);
    rst = 1'b0;
    step(2);
    check("R1 after reset", '0);

    // R2: each pin alone lands on its swizzled line
    for (int i = 0; i < NP; i++) begin
      pin_lvl = '0;
      pin_lvl[i] = 1'b1;
      step(SETTLE);
      check($sformatf("R2 pin %0d line %0d", i, ((i / PN) + (i % PN)) % LN),
            LN'(1) << (((i / PN) + (i % PN)) % LN));
      pin_lvl = '0;
      settle_check("R3 single pin drop");
    end

    // R6: latency of a single change (pin 5 -> line 2)
    pin_lvl[5] = 1'b1;
    step(2);
    check("R6 rise not yet", '0);
    step(1);
    check("R6 rise at third edge", 4'b0100);
    pin_lvl[5] = 1'b0;
    step(2);
    check("R6 fall not yet", 4'b0100);
    step(1);
    check("R6 fall at third edge", '0);
    step(4);

    // R3: shared line stays high until the last routed pin drops
    pin_lvl[0] = 1'b1;
    pin_lvl[7] = 1'b1;
    settle_check("R3 two pins on line 0");
    pin_lvl[0] = 1'b0;
    step(SETTLE);
    check("R3 one of two dropped", 4'b0001);
    pin_lvl[7] = 1'b0;
    step(SETTLE);
    check("R3 both dropped", '0);

    // R4: holding a level is ignored; one fall clears the line
    pin_lvl[9] = 1'b1;
    step(SETTLE);
    for (int c = 0; c < 20; c++) begin
      pin_lvl[9] = 1'b1;
      step(1);
    end
    check("R4 held high", 4'b1000);
    pin_lvl[9] = 1'b0;
    step(SETTLE);
    check("R4 single fall clears", '0);

    // R5: burst from zero, one change per cycle, ascending index
    pin_lvl = '1;
    step(2);
    check("R5 burst nothing yet", '0);
    for (int k = 0; k < LN; k++) begin
      step(1);
      check($sformatf("R5 burst line %0d order", k), LN'((1 << (k + 1)) - 1));
    end
    // R7: all pins high then all low
    step(SETTLE);
    check("R7 all pins high", '1);
    pin_lvl = '0;
    step(SETTLE);
    check("R7 all pins low", '0);

    // R1: reset with pins high, release with pins still high
    pin_lvl = '1;
    step(SETTLE);
    rst = 1'b1;
    step(2);
    check("R1 reset clears lines", '0);
    rst = 1'b0;
    step(SETTLE);
    check("R1 high pin recounted after reset", '1);
    pin_lvl = '0;
    step(SETTLE);
    check("R1 stored levels cleared", '0);

    // R3: pseudo-random patterns against the OR model
    lfsr = 32'hACE1_2468;
    for (int t = 0; t < 200; t++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pin_lvl = lfsr[NP-1:0];
      settle_check($sformatf("R3 pattern %0d", t));
    end
    pin_lvl = '0;
    settle_check("R7 final drain");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule